// File: doc/BRIEF.md
# Display Command Packet Parser

This block sits at the input of a display engine and takes in one 32-bit command word per handshake. It groups the stream into complete packets. The top byte of the first word of each packet is the opcode, and the opcode sets how many argument words follow. When a packet is complete, the block sends it to one of three places.

- **Drawing packets** go whole to a renderer port, one word per handshake.
- **Environment packets** (opcodes 0xE0 to 0xE7) are stored in a bank of eight shadow registers.
- **Image-transfer packets** (0xA0 writes into frame memory, 0xC0 reads from it) pass their position and size words to a rectangle transfer unit as a single-cycle pulse.

Textured primitives also update the texture-page field of shadow register 1 as they pass through. A 13-bit status field tracks shadow registers 1 and 6. A packet whose words are still arriving is held in an internal buffer until its last word comes in. The input stalls while a finished packet is being dispatched or forwarded.

Top module: `disp_cmd_parser`

## Requirements
- R1: The number of argument words after the first word depends on opcode bits 31:24:
  - 0x02→2
  - 0x20–0x23→3, 0x24–0x27→6, 0x28–0x2B→4, 0x2C–0x2F→8
  - 0x30–0x33→5, 0x34–0x37→8, 0x38–0x3B→7, 0x3C–0x3F→11
  - 0x40–0x47→2, 0x48–0x57→3, 0x58–0x5F→4
  - 0x60–0x63→2, 0x64–0x67→3, 0x68–0x6B→1, 0x6C–0x6F→0
  - 0x70–0x73→1, 0x74–0x77→2, 0x78–0x7B→1, 0x7C–0x7F→2
  - 0x80→3, 0xA0→2, 0xC0→2
  - every other opcode→0
- R2: Every packet that is neither an environment packet nor a transfer packet appears on the renderer port. All its words come out in order, and `draw_last` is high only on the final word. While `draw_ready` is low, `draw_data` and `draw_last` hold their values.
- R3: For opcodes 0xE0–0xE7, the whole one-word packet is written into shadow register (opcode & 7). Nothing is forwarded to the renderer, and the other shadow registers keep their values.
- R4: When (opcode & 0xF4) == 0x24, bits 8:0 of packet word index 4 (word 0 is the command word) replace bits 8:0 of shadow register 1. Its upper bits are kept.
- R5: When (opcode & 0xF4) == 0x34, bits 8:0 of packet word index 5 replace bits 8:0 of shadow register 1. Word index 4 has no effect on that register.
- R6: `status_lo` bits 10:0 equal shadow register 1 bits 10:0. `status_lo` bits 12:11 equal shadow register 6 bits 1:0. The status changes on the same clock edge as the shadow registers.
- R7: A completed packet with 0x02 ≤ opcode < 0xC0 raises `mem_dirty` for exactly one cycle. No other packet raises it.
- R8: For a completed 0xA0 or 0xC0 packet, `xfer_valid` is high for one cycle, carrying:
  - `xfer_pos` = word index 1
  - `xfer_size` = word index 2
  - `xfer_read` = 1 only for 0xC0

  Nothing is forwarded to the renderer for these packets.
- R9: A packet whose words are still arriving produces no renderer output, no shadow update and no pulse, however long the gaps between its words.
- R10: After reset:
  - shadow register i holds (0xE0 + i) << 24
  - `status_lo` is 0
  - `in_ready` is 1
  - `draw_valid`, `xfer_valid` and `mem_dirty` are 0
- R11: `in_ready` is low while a completed packet is being dispatched or forwarded. No input word is lost or duplicated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Parser takes the word this cycle |
| in_data | input | 32 | Command word |
| draw_valid | output | 1 | Renderer word valid |
| draw_ready | input | 1 | Renderer accepts word |
| draw_data | output | 32 | Renderer word |
| draw_last | output | 1 | Final word of the forwarded packet |
| xfer_valid | output | 1 | Transfer request pulse |
| xfer_read | output | 1 | 1 = read from frame memory, 0 = write |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| mem_dirty | output | 1 | Frame memory touched by the last packet |
| shadow_regs | output | 256 | Shadow registers, register i at bits 32i+31:32i |
| status_lo | output | 13 | Status bits 12:0 |

## Verification
The bench covers the following corner cases, and what a faulty design would do in each:

- **Gapped input.** A packet is fed with long gaps between its words. A parser that trusted arrival timing instead of the length lookup would forward a short packet.
- **Two texture-bearing primitives.** One carries its field in word index 4 and the other in word index 5, and the two words hold different values. A design that mixed up the indices, or cleared bits 10:9 of shadow register 1, would show a wrong value on `status_lo`.
- **Stalled renderer with long packets.** A long packet is forwarded while `draw_ready` toggles. This exposes dropped or repeated words and a premature `draw_last`.
- **Length and dirty boundaries.** A zero-argument opcode and both transfer opcodes are sent. These catch off-by-one lengths, transfer packets leaking onto the renderer port, and a dirty flag raised for the read transfer.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned NUM_SHADOW = 8;
    localparam int unsigned STAT_W     = 13;
    localparam int unsigned TEX_W      = 9;
    localparam int unsigned LEN_W      = 4;

    typedef enum logic [0:0] {
        ST_COLLECT = 1'b0,
        ST_EMIT    = 1'b1
    } dcp_state_e;

    typedef enum logic [1:0] {
        PK_DRAW = 2'd0,
        PK_ENV  = 2'd1,
        PK_XFER = 2'd2
    } pkt_kind_e;

    typedef logic [NUM_SHADOW-1:0][WORD_W-1:0] shadow_bank_t;

    // Argument words that follow the command word, selected by opcode.
    function automatic logic [LEN_W-1:0] arg_count(input logic [7:0] op);
        logic [LEN_W-1:0] n;
        case (op) inside
            8'h02:           n = 4'd2;
            [8'h20:8'h23]:   n = 4'd3;
            [8'h24:8'h27]:   n = 4'd6;
            [8'h28:8'h2B]:   n = 4'd4;
            [8'h2C:8'h2F]:   n = 4'd8;
            [8'h30:8'h33]:   n = 4'd5;
            [8'h34:8'h37]:   n = 4'd8;
            [8'h38:8'h3B]:   n = 4'd7;
            [8'h3C:8'h3F]:   n = 4'd11;
            [8'h40:8'h47]:   n = 4'd2;
            [8'h48:8'h57]:   n = 4'd3;
            [8'h58:8'h5F]:   n = 4'd4;
            [8'h60:8'h63]:   n = 4'd2;
            [8'h64:8'h67]:   n = 4'd3;
            [8'h68:8'h6B]:   n = 4'd1;
            [8'h6C:8'h6F]:   n = 4'd0;
            [8'h70:8'h73]:   n = 4'd1;
            [8'h74:8'h77]:   n = 4'd2;
            [8'h78:8'h7B]:   n = 4'd1;
            [8'h7C:8'h7F]:   n = 4'd2;
            8'h80:           n = 4'd3;
            8'hA0:           n = 4'd2;
            8'hC0:           n = 4'd2;
            default:         n = 4'd0;
        endcase
        return n;
    endfunction

    function automatic pkt_kind_e classify(input logic [7:0] op);
        if (op[7:3] == 5'b11100)
            return PK_ENV;
        else if (op == 8'hA0 || op == 8'hC0)
            return PK_XFER;
        else
            return PK_DRAW;
    endfunction

    function automatic shadow_bank_t shadow_reset();
        shadow_bank_t r;
        for (int i = 0; i < NUM_SHADOW; i++)
            r[i] = {8'hE0 + 8'(i), 24'h000000};
        return r;
    endfunction

endpackage

// File: rtl/dcp_assembler.sv
module dcp_assembler
    import disp_cmd_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 12,
    localparam int unsigned CNT_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               push,
    input  logic [WORD_W-1:0]                  push_word,
    input  logic                               clear,
    output logic [MAX_WORDS-1:0][WORD_W-1:0]   words,
    output logic [CNT_W-1:0]                   total,
    output logic                               complete
);

    typedef struct packed {
        logic [MAX_WORDS-1:0][WORD_W-1:0] words;
        logic [CNT_W-1:0]                 cnt;
        logic [CNT_W-1:0]                 total;
    } asm_st_t;

    asm_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (push) begin
            if (st_q.cnt == '0)
                st_d.total = CNT_W'(arg_count(push_word[31:24])) + CNT_W'(1);
            st_d.words[st_q.cnt] = push_word;
            st_d.cnt             = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign words    = st_q.words;
    assign total    = st_q.total;
    assign complete = (st_q.cnt != '0) && (st_q.cnt == st_q.total);

endmodule

// File: rtl/dcp_shadow_bank.sv
module dcp_shadow_bank
    import disp_cmd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         env_we,
    input  logic [2:0]                   env_idx,
    input  logic [WORD_W-1:0]            env_word,
    input  logic                         tex_we,
    input  logic [TEX_W-1:0]             tex_bits,
    output logic [NUM_SHADOW*WORD_W-1:0] shadow_flat,
    output logic [STAT_W-1:0]            status_lo
);

    typedef struct packed {
        shadow_bank_t        regs;
        logic [STAT_W-1:0]   status;
    } bank_st_t;

    bank_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (env_we)
            st_d.regs[env_idx] = env_word;
        if (tex_we)
            st_d.regs[1][TEX_W-1:0] = tex_bits;
        st_d.status = {st_d.regs[6][1:0], st_d.regs[1][10:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs   <= shadow_reset();
            st_q.status <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_flat = st_q.regs;
    assign status_lo   = st_q.status;

endmodule

// File: rtl/dcp_draw_emitter.sv
module dcp_draw_emitter
    import disp_cmd_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 12,
    localparam int unsigned CNT_W    = $clog2(MAX_WORDS + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             active,
    input  logic [MAX_WORDS-1:0][WORD_W-1:0] words,
    input  logic [CNT_W-1:0]                 total,
    input  logic                             out_ready,
    output logic                             out_valid,
    output logic [WORD_W-1:0]                out_data,
    output logic                             out_last,
    output logic                             done
);

    typedef struct packed {
        logic [CNT_W-1:0] idx;
    } emit_st_t;

    emit_st_t st_q, st_d;
    logic     fire;

    always_comb begin
        st_d      = st_q;
        out_valid = active;
        out_data  = words[st_q.idx];
        out_last  = (st_q.idx == total - CNT_W'(1));
        fire      = active && out_ready;
        done      = fire && out_last;
        if (fire)
            st_d.idx = out_last ? '0 : st_q.idx + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/disp_cmd_parser.sv
module disp_cmd_parser
    import disp_cmd_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [WORD_W-1:0]            in_data,
    output logic                         draw_valid,
    input  logic                         draw_ready,
    output logic [WORD_W-1:0]            draw_data,
    output logic                         draw_last,
    output logic                         xfer_valid,
    output logic                         xfer_read,
    output logic [WORD_W-1:0]            xfer_pos,
    output logic [WORD_W-1:0]            xfer_size,
    output logic                         mem_dirty,
    output logic [NUM_SHADOW*WORD_W-1:0] shadow_regs,
    output logic [STAT_W-1:0]            status_lo
);

    localparam int unsigned CNT_W = $clog2(MAX_WORDS + 1);

    typedef struct packed {
        dcp_state_e        state;
        logic              xfer_v;
        logic              xfer_rd;
        logic [WORD_W-1:0] xfer_pos;
        logic [WORD_W-1:0] xfer_size;
        logic              dirty;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [MAX_WORDS-1:0][WORD_W-1:0] pkt_words;
    logic [CNT_W-1:0]                 pkt_total;
    logic                             pkt_complete;
    logic                             push, asm_clear;
    logic                             dispatch;
    logic [7:0]                       op;
    pkt_kind_e                        kind;
    logic                             env_we, tex_we;
    logic [TEX_W-1:0]                 tex_bits;
    logic                             emit_active, emit_done;

    always_comb begin
        st_d        = st_q;
        st_d.xfer_v = 1'b0;
        st_d.dirty  = 1'b0;
        op          = pkt_words[0][31:24];
        kind        = classify(op);
        dispatch    = (st_q.state == ST_COLLECT) && pkt_complete;
        in_ready    = (st_q.state == ST_COLLECT) && !pkt_complete;
        push        = in_valid && in_ready;
        emit_active = (st_q.state == ST_EMIT);
        asm_clear   = 1'b0;
        env_we      = 1'b0;
        tex_we      = 1'b0;
        tex_bits    = '0;

        if (dispatch) begin
            st_d.dirty = (op >= 8'h02) && (op < 8'hC0);
            case (kind)
                PK_ENV: begin
                    env_we    = 1'b1;
                    asm_clear = 1'b1;
                end
                PK_XFER: begin
                    st_d.xfer_v    = 1'b1;
                    st_d.xfer_rd   = (op == 8'hC0);
                    st_d.xfer_pos  = pkt_words[1];
                    st_d.xfer_size = pkt_words[2];
                    asm_clear      = 1'b1;
                end
                default: begin
                    st_d.state = ST_EMIT;
                    if ((op & 8'hF4) == 8'h24) begin
                        tex_we   = 1'b1;
                        tex_bits = pkt_words[4][TEX_W-1:0];
                    end else if ((op & 8'hF4) == 8'h34) begin
                        tex_we   = 1'b1;
                        tex_bits = pkt_words[5][TEX_W-1:0];
                    end
                end
            endcase
        end

        if (emit_active && emit_done) begin
            asm_clear  = 1'b1;
            st_d.state = ST_COLLECT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_COLLECT;
        end else begin
            st_q <= st_d;
        end
    end

    dcp_assembler #(.MAX_WORDS(MAX_WORDS)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (in_data),
        .clear     (asm_clear),
        .words     (pkt_words),
        .total     (pkt_total),
        .complete  (pkt_complete)
    );

    dcp_draw_emitter #(.MAX_WORDS(MAX_WORDS)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (emit_active),
        .words     (pkt_words),
        .total     (pkt_total),
        .out_ready (draw_ready),
        .out_valid (draw_valid),
        .out_data  (draw_data),
        .out_last  (draw_last),
        .done      (emit_done)
    );

    dcp_shadow_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .env_we      (env_we),
        .env_idx     (op[2:0]),
        .env_word    (pkt_words[0]),
        .tex_we      (tex_we),
        .tex_bits    (tex_bits),
        .shadow_flat (shadow_regs),
        .status_lo   (status_lo)
    );

    assign xfer_valid = st_q.xfer_v;
    assign xfer_read  = st_q.xfer_rd;
    assign xfer_pos   = st_q.xfer_pos;
    assign xfer_size  = st_q.xfer_size;
    assign mem_dirty  = st_q.dirty;

endmodule

// File: rtl/dcp_checker.sv
module dcp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        draw_valid,
    input logic        draw_ready,
    input logic [31:0] draw_data,
    input logic        draw_last,
    input logic        xfer_valid,
    input logic        mem_dirty
);

    // R2: a stalled renderer word stays put
    a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        draw_valid && !draw_ready |=> draw_valid && $stable(draw_data) && $stable(draw_last));

    // R11: no intake while a packet is being forwarded
    a_r11_no_intake_during_emit: assert property (@(posedge clk) disable iff (!rst_n)
        draw_valid |-> !in_ready);

    // R8: transfer request is a single-cycle pulse
    a_r8_xfer_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> !xfer_valid);

    // R8: a transfer request never coincides with renderer output
    a_r8_xfer_not_drawn: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !draw_valid);

    // R7: dirty indication is a single-cycle pulse
    a_r7_dirty_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dirty |=> !mem_dirty);

endmodule

bind disp_cmd_parser dcp_checker u_dcp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .draw_valid (draw_valid),
    .draw_ready (draw_ready),
    .draw_data  (draw_data),
    .draw_last  (draw_last),
    .xfer_valid (xfer_valid),
    .mem_dirty  (mem_dirty)
);

// File: tb/disp_cmd_parser_test.sv
`timescale 1ns/1ps
module disp_cmd_parser_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         draw_valid;
    logic         draw_ready = 1'b1;
    logic [31:0]  draw_data;
    logic         draw_last;
    logic         xfer_valid;
    logic         xfer_read;
    logic [31:0]  xfer_pos;
    logic [31:0]  xfer_size;
    logic         mem_dirty;
    logic [255:0] shadow_regs;
    logic [12:0]  status_lo;

    always #10 clk = ~clk;

    disp_cmd_parser uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .draw_valid(draw_valid), .draw_ready(draw_ready), .draw_data(draw_data), .draw_last(draw_last),
        .xfer_valid(xfer_valid), .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .mem_dirty(mem_dirty), .shadow_regs(shadow_regs), .status_lo(status_lo)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic stall_mode = 1'b0;

    logic [31:0] cap_data [64];
    logic        cap_last [64];
    int          cap_n = 0;
    int          xfer_n = 0;
    int          dirty_n = 0;
    int          ready_viol = 0;
    logic        lx_rd;
    logic [31:0] lx_pos, lx_size;
    logic [31:0] pkt [12];

    always @(posedge clk) draw_ready <= stall_mode ? ~draw_ready : 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (draw_valid && draw_ready) begin
                cap_data[cap_n[5:0]] <= draw_data;
                cap_last[cap_n[5:0]] <= draw_last;
                cap_n <= cap_n + 1;
            end
            if (draw_valid && in_ready) ready_viol <= ready_viol + 1;
            if (xfer_valid) begin
                xfer_n <= xfer_n + 1;
                lx_rd <= xfer_read; lx_pos <= xfer_pos; lx_size <= xfer_size;
            end
            if (mem_dirty) dirty_n <= dirty_n + 1;
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            finish_run();
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sh(input int i);
        return shadow_regs[i*32 +: 32];
    endfunction

    task automatic send_word(input logic [31:0] w);
        logic r;
        in_data = w;
        in_valid = 1'b1;
        forever begin
            r = in_ready;
            @(negedge clk);
            if (r) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            send_word(pkt[i]);
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    task automatic check_draw(input string tag, input int base, input int n);
        check({tag, " word count"}, 32'(cap_n - base), 32'(n));
        for (int i = 0; i < n; i++) begin
            check({tag, " word"}, cap_data[(base + i) % 64], pkt[i]);
            check({tag, " last flag"}, 32'(cap_last[(base + i) % 64]), 32'(i == n - 1));
        end
    endtask

    // R10
    task automatic t_reset();
        for (int i = 0; i < 8; i++)
            check("R10 shadow reset", sh(i), {8'hE0 + 8'(i), 24'h0});
        check("R10 status reset", 32'(status_lo), 32'h0);
        check("R10 in_ready reset", 32'(in_ready), 32'h1);
        check("R10 outputs idle", {29'h0, draw_valid, xfer_valid, mem_dirty}, 32'h0);
    endtask

    // R3 R6 R7
    task automatic t_env();
        int b = cap_n, d = dirty_n;
        pkt[0] = 32'hE100_0723; send_pkt(1, 0); settle();
        check("R3 shadow1 written", sh(1), 32'hE100_0723);
        check("R6 status from shadow1", 32'(status_lo), 32'h0723);
        pkt[0] = 32'hE600_0003; send_pkt(1, 0); settle();
        check("R3 shadow6 written", sh(6), 32'hE600_0003);
        check("R6 status from shadow6", 32'(status_lo), 32'h1F23);
        pkt[0] = 32'hE3AB_CDEF; send_pkt(1, 0); settle();
        check("R3 shadow3 written", sh(3), 32'hE3AB_CDEF);
        check("R3 shadow0 untouched", sh(0), 32'hE000_0000);
        check("R6 status unchanged by shadow3", 32'(status_lo), 32'h1F23);
        check("R3 env not forwarded", 32'(cap_n - b), 32'h0);
        check("R7 env not dirty", 32'(dirty_n - d), 32'h0);
    endtask

    // R1 R2 R4 R7
    task automatic t_flat_tex();
        int b = cap_n, d = dirty_n;
        pkt[0] = 32'h2480_8080;
        for (int i = 1; i < 7; i++) pkt[i] = 32'h0001_1000 + 32'(i);
        pkt[4] = 32'h1234_F7A5;
        send_pkt(7, 0); settle();
        check_draw("R1 R2 flat textured", b, 7);
        check("R4 shadow1 texture bits", sh(1), 32'hE100_07A5);
        check("R6 status after flat tex", 32'(status_lo), 32'h1FA5);
        check("R7 draw dirty", 32'(dirty_n - d), 32'h1);
    endtask

    // R5 R2 under renderer stalls
    task automatic t_shaded_tex();
        int b = cap_n;
        pkt[0] = 32'h3400_1111;
        for (int i = 1; i < 9; i++) pkt[i] = 32'hA5A5_0000 + 32'(i * 3);
        pkt[4] = 32'h0000_01FF;
        pkt[5] = 32'h0000_00F0;
        stall_mode = 1'b1;
        send_pkt(9, 0); settle();
        stall_mode = 1'b0;
        check_draw("R2 shaded under stall", b, 9);
        check("R5 shadow1 from word 5", sh(1), 32'hE100_06F0);
        check("R6 status after shaded tex", 32'(status_lo), 32'h1EF0);
    endtask

    // R9 R1
    task automatic t_partial();
        int b = cap_n, d = dirty_n;
        pkt[0] = 32'h2011_2233; pkt[1] = 32'h0000_0001; pkt[2] = 32'h0002_0002; pkt[3] = 32'h0003_0003;
        for (int i = 0; i < 3; i++) begin
            send_word(pkt[i]);
            repeat (12) @(negedge clk);
        end
        check("R9 partial not forwarded", 32'(cap_n - b), 32'h0);
        check("R9 partial no dirty", 32'(dirty_n - d), 32'h0);
        check("R9 still accepting", 32'(in_ready), 32'h1);
        send_word(pkt[3]); settle();
        check_draw("R9 R1 gapped packet", b, 4);
    endtask

    // R1 zero and one argument
    task automatic t_short();
        int b = cap_n;
        pkt[0] = 32'h6C00_0042; send_pkt(1, 0); settle();
        check_draw("R1 zero-argument", b, 1);
        b = cap_n;
        pkt[0] = 32'h6812_3456; pkt[1] = 32'h0044_0055; send_pkt(2, 0); settle();
        check_draw("R1 one-argument", b, 2);
    endtask

    // R8 R7
    task automatic t_xfer();
        int b = cap_n, d = dirty_n, x = xfer_n;
        pkt[0] = 32'hA000_0000; pkt[1] = 32'h0010_0020; pkt[2] = 32'h0008_0010;
        send_pkt(3, 0); settle();
        check("R8 write xfer pulse", 32'(xfer_n - x), 32'h1);
        check("R8 write direction", 32'(lx_rd), 32'h0);
        check("R8 write pos", lx_pos, 32'h0010_0020);
        check("R8 write size", lx_size, 32'h0008_0010);
        check("R7 write xfer dirty", 32'(dirty_n - d), 32'h1);
        pkt[0] = 32'hC000_0000; pkt[1] = 32'h0020_0040; pkt[2] = 32'h0002_0002;
        send_pkt(3, 1); settle();
        check("R8 read xfer pulse", 32'(xfer_n - x), 32'h2);
        check("R8 read direction", 32'(lx_rd), 32'h1);
        check("R8 read pos", lx_pos, 32'h0020_0040);
        check("R8 read size", lx_size, 32'h0002_0002);
        check("R7 read xfer not dirty", 32'(dirty_n - d), 32'h1);
        check("R8 xfer not forwarded", 32'(cap_n - b), 32'h0);
    endtask

    // R11: back-to-back packets with no loss
    task automatic t_back_to_back();
        int b = cap_n;
        pkt[0] = 32'h6C00_0001; send_word(pkt[0]);
        pkt[1] = 32'h6C00_0002; send_word(pkt[1]);
        pkt[2] = 32'h6C00_0003; send_word(pkt[2]);
        settle();
        check("R11 word count", 32'(cap_n - b), 32'h3);
        for (int i = 0; i < 3; i++)
            check("R11 order kept", cap_data[(b + i) % 64], pkt[i]);
        check("R11 no intake during emit", 32'(ready_viol), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_env();
        t_flat_tex();
        t_shaded_tex();
        t_partial();
        t_short();
        t_xfer();
        t_back_to_back();
        finish_run();
    end

endmodule